// File: doc/BRIEF.md
# Word-Sampled Pulse Time-to-Digital Converter

This block timestamps detector pulses and measures how long they last. A high-speed serial receiver has already oversampled the detector line, and the samples arrive here as 16-bit parallel words, one per reference-clock period. Each sample stands for one serial bit period, which is 400 ps at a 6.4 ns word period. Bit 15 of a word is its earliest sample.

A coarse counter numbers the accepted words. The bit position of a rising transition inside its word gives the fine part of the time. High runs that cross word boundaries are joined into a single pulse. When the falling transition is seen, the block emits one record. The record holds the leading-edge time and the pulse width, both counted in bit periods, plus an overflow flag. A start input restarts the time base.

Top module: `tdc_core`

## Requirements
- R1: After `rst` the output strobe `rec_valid` is low and no pulse is in progress, so a later word that begins with zero bits produces no record.
- R2: The leading-edge time in `rec_time` equals the word index times 16, plus the number of zero bits before the first set bit. Zero bits are counted from bit 15, the earliest sample, towards bit 0.
- R3: The word index counts the words accepted since the last `start` or reset, and wraps silently at 2^20. A cycle with `word_valid` low is neither counted nor analysed. A cycle with `start` high clears the index to zero, drops any pulse in progress and ignores its word.
- R4: `rec_width` is the number of set bits in the pulse's high run. `rec_valid` pulses high for exactly one cycle, in the cycle after the word containing the pulse's falling transition is accepted. This also covers a word whose bit 15 is zero right after a run that filled the previous word.
- R5: A pulse that spans several consecutive words is reported once. Its width adds up its set bits across all those words. All-zero words before a pulse only advance the word index.
- R6: A pulse of a single set bit is reported with width 1.
- R7: A word that ends a pulse can also start a new one. A high run that reaches bit 0 of that word opens a new measurement, with its leading edge at 16 minus the length of that run.
- R8: At most one record comes from each word. A pulse that both starts and ends inside a word after that word has already closed a pulse is discarded.
- R9: Widths above 4095 are reported as 4095 with `rec_ovf` set. A width of exactly 4095 is reported with `rec_ovf` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (word) clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart: clears the word index and aborts any open pulse |
| word_valid | input | 1 | `word_data` holds a sampled word this cycle |
| word_data | input | 16 | Sampled word, bit 15 earliest |
| rec_valid | output | 1 | One-cycle strobe for a completed pulse record |
| rec_time | output | 24 | Leading-edge time in bit periods |
| rec_width | output | 12 | Pulse width in bit periods, saturating |
| rec_ovf | output | 1 | Width exceeded the 12-bit range |

## Verification
Every record is due one clock edge after the word that holds the falling transition. The record is registered at that edge, with nothing in between. The bench therefore sets each word up at a falling clock edge and samples the outputs 2 ns after the next rising edge. At that point it compares the strobe and the fields with a bit-serial reference model that has consumed the same word. Cycles with an invalid word and start cycles are checked at the same point, where the expected strobe is low. A new record cannot appear before the following accepted word, so every word is judged in the one cycle it can affect.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
    localparam int WORD_W   = 16;
    localparam int COARSE_W = 20;
    localparam int FINE_W   = $clog2(WORD_W);
    localparam int POS_W    = FINE_W + 1;
    localparam int TIME_W   = COARSE_W + FINE_W;
    localparam int WIDTH_W  = 12;

    typedef logic [POS_W-1:0] pos_t;

    // Per-word summary of the sample pattern, all counts from the MSB side
    // except trail, which counts set bits up from bit 0.
    typedef struct packed {
        pos_t lead;   // set bits before the first zero
        pos_t first;  // zero bits before the first set bit
        pos_t run;    // length of the first high run
        pos_t trail;  // set bits ending at bit 0
        logic empty;
        logic full;
    } scan_t;

    typedef struct packed {
        logic [TIME_W-1:0]  time_b;
        logic [WIDTH_W-1:0] width;
        logic               ovf;
    } rec_t;

    typedef enum logic {ST_IDLE, ST_HIGH} trk_state_e;

    function automatic pos_t lead_ones(input logic [WORD_W-1:0] w);
        pos_t n    = '0;
        logic stop = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!stop && w[i]) n = n + pos_t'(1);
            else               stop = 1'b1;
        end
        return n;
    endfunction

    function automatic pos_t lead_zeros(input logic [WORD_W-1:0] w);
        pos_t n    = '0;
        logic stop = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!stop && !w[i]) n = n + pos_t'(1);
            else                stop = 1'b1;
        end
        return n;
    endfunction

    function automatic pos_t run_after(input logic [WORD_W-1:0] w, input pos_t skip);
        pos_t n    = '0;
        logic stop = 1'b0;
        for (int p = 0; p < WORD_W; p++) begin
            if (p >= int'(skip) && !stop) begin
                if (w[WORD_W-1-p]) n = n + pos_t'(1);
                else               stop = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic pos_t tail_ones(input logic [WORD_W-1:0] w);
        pos_t n    = '0;
        logic stop = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            if (!stop && w[i]) n = n + pos_t'(1);
            else               stop = 1'b1;
        end
        return n;
    endfunction

    // MSB of the result flags overflow; the rest is the saturated sum.
    function automatic logic [WIDTH_W:0] sat_add(input logic [WIDTH_W-1:0] a, input pos_t b);
        logic [WIDTH_W:0] s;
        s = {1'b0, a} + {{(WIDTH_W + 1 - POS_W){1'b0}}, b};
        if (s[WIDTH_W]) return {1'b1, {WIDTH_W{1'b1}}};
        return s;
    endfunction
endpackage

// File: rtl/tdc_coarse.sv
`timescale 1ns/1ps
module tdc_coarse
    import tdc_pkg::*;
#(
    parameter int CW = COARSE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (adv)    count <= count + CW'(1);
    end
endmodule

// File: rtl/tdc_word_scan.sv
`timescale 1ns/1ps
module tdc_word_scan
    import tdc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output scan_t             info
);
    pos_t first_z;

    always_comb begin
        first_z    = lead_zeros(word);
        info.lead  = lead_ones(word);
        info.first = first_z;
        info.run   = run_after(word, first_z);
        info.trail = tail_ones(word);
        info.empty = (word == '0);
        info.full  = (word == '1);
    end
endmodule

// File: rtl/tdc_tracker.sv
`timescale 1ns/1ps
module tdc_tracker
    import tdc_pkg::*;
#(
    parameter int CW = COARSE_W,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  scan_t         info,
    input  logic [CW-1:0] coarse,
    output logic          rec_valid,
    output rec_t          rec
);
    trk_state_e         state, nx_state;
    logic [TW-1:0]      t0, nx_t0;
    logic [WIDTH_W-1:0] acc, nx_acc;
    logic               acc_ovf, nx_ovf;
    logic               emit, open_tail;
    rec_t               em;
    logic [TW-1:0]      base, first_t, tail_t;
    logic [WIDTH_W:0]   grown;
    logic               reach_end;

    assign base      = {coarse, FINE_W'(0)};
    assign first_t   = base + TW'(info.first);
    assign tail_t    = base + TW'(WORD_W) - TW'(info.trail);
    assign grown     = sat_add(acc, info.lead);
    assign reach_end = (info.first + info.run) == pos_t'(WORD_W);

    always_comb begin
        nx_state  = state;
        nx_t0     = t0;
        nx_acc    = acc;
        nx_ovf    = acc_ovf;
        emit      = 1'b0;
        open_tail = 1'b0;
        em        = '0;
        if (adv) begin
            unique case (state)
                ST_HIGH: begin
                    if (info.full) begin
                        nx_acc = grown[WIDTH_W-1:0];
                        nx_ovf = acc_ovf | grown[WIDTH_W];
                    end else begin
                        emit      = 1'b1;
                        em.time_b = t0;
                        em.width  = grown[WIDTH_W-1:0];
                        em.ovf    = acc_ovf | grown[WIDTH_W];
                        open_tail = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (!info.empty) begin
                        if (reach_end) begin
                            nx_state = ST_HIGH;
                            nx_t0    = first_t;
                            nx_acc   = WIDTH_W'(info.run);
                            nx_ovf   = 1'b0;
                        end else begin
                            emit      = 1'b1;
                            em.time_b = first_t;
                            em.width  = WIDTH_W'(info.run);
                            em.ovf    = 1'b0;
                            open_tail = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (open_tail) begin
                if (info.trail != '0) begin
                    nx_state = ST_HIGH;
                    nx_t0    = tail_t;
                    nx_acc   = WIDTH_W'(info.trail);
                    nx_ovf   = 1'b0;
                end else begin
                    nx_state = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state     <= ST_IDLE;
            t0        <= '0;
            acc       <= '0;
            acc_ovf   <= 1'b0;
            rec_valid <= 1'b0;
            rec       <= '0;
        end else begin
            state     <= nx_state;
            t0        <= nx_t0;
            acc       <= nx_acc;
            acc_ovf   <= nx_ovf;
            rec_valid <= emit;
            if (emit) rec <= em;
        end
    end
endmodule

// File: rtl/tdc_core.sv
`timescale 1ns/1ps
module tdc_core
    import tdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    output logic               rec_valid,
    output logic [TIME_W-1:0]  rec_time,
    output logic [WIDTH_W-1:0] rec_width,
    output logic               rec_ovf
);
    logic [COARSE_W-1:0] coarse_q;
    logic                take;
    scan_t               info;
    rec_t                rec;

    assign take = word_valid && !start;

    tdc_coarse #(.CW(COARSE_W)) u_coarse (
        .clk(clk), .rst(rst), .clr(start), .adv(take), .count(coarse_q)
    );

    tdc_word_scan u_scan (
        .word(word_data), .info(info)
    );

    tdc_tracker #(.CW(COARSE_W), .TW(TIME_W)) u_track (
        .clk(clk), .rst(rst), .clr(start), .adv(take), .info(info),
        .coarse(coarse_q), .rec_valid(rec_valid), .rec(rec)
    );

    assign rec_time  = rec.time_b;
    assign rec_width = rec.width;
    assign rec_ovf   = rec.ovf;
endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker
    import tdc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                word_valid,
    input logic                rec_valid,
    input logic [WIDTH_W-1:0]  rec_width,
    input logic                rec_ovf,
    input logic [COARSE_W-1:0] coarse
);
    // R4: a record only follows an accepted word
    p_strobe_src_r4: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> $past(word_valid && !start));

    // R3: start clears the word index and suppresses any record
    p_start_clear_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (coarse == '0 && !rec_valid));

    // R3: one step of the index per accepted word
    p_coarse_step_r3: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !start) |=> coarse == $past(coarse) + COARSE_W'(1));

    // R3: cycles without a word leave the index alone
    p_coarse_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && !start) |=> $stable(coarse));

    // R8: no word, no record
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !word_valid |=> !rec_valid);

    // R9: overflow always comes with a saturated width
    p_ovf_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ovf) |-> rec_width == '1);

    // R6: a reported pulse holds at least one set bit
    p_width_nz_r6: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_width != '0);
endmodule

bind tdc_core tdc_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
    .rec_valid(rec_valid), .rec_width(rec_width), .rec_ovf(rec_ovf),
    .coarse(coarse_q)
);

// File: tb/sim_tdc_core.sv
`timescale 1ns/1ps
module sim_tdc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        rec_valid;
    logic [23:0] rec_time;
    logic [11:0] rec_width;
    logic        rec_ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    tdc_core u0 (
        .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
        .word_data(word_data), .rec_valid(rec_valid), .rec_time(rec_time),
        .rec_width(rec_width), .rec_ovf(rec_ovf)
    );

    // bit-serial reference model
    int m_coarse = 0;
    bit m_in     = 0;
    int m_t0     = 0;
    int m_w      = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_word(input logic [15:0] w, output bit ev, output int et,
                              output int ew, output bit eo);
        bit emitted = 0;
        ev = 0; et = 0; ew = 0; eo = 0;
        for (int p = 0; p < 16; p++) begin
            if (m_in) begin
                if (w[15-p]) m_w++;
                else begin
                    m_in = 0;
                    if (!emitted) begin
                        emitted = 1; ev = 1; et = m_t0;
                        ew = (m_w > 4095) ? 4095 : m_w;
                        eo = (m_w > 4095);
                    end
                end
            end else if (w[15-p]) begin
                m_in = 1; m_t0 = m_coarse * 16 + p; m_w = 1;
            end
        end
        m_coarse = (m_coarse + 1) % (1 << 20);
    endtask

    task automatic step(input logic [15:0] w, input bit v, input bit s, input string tag);
        bit ev; int et; int ew; bit eo;
        @(negedge clk);
        word_data = w; word_valid = v; start = s;
        ev = 0; et = 0; ew = 0; eo = 0;
        if (s) begin m_in = 0; m_coarse = 0; end
        else if (v) model_word(w, ev, et, ew, eo);
        @(posedge clk);
        #2;
        check(rec_valid == ev, {tag, " strobe"}, int'(rec_valid), int'(ev));
        if (ev) begin
            check(int'(rec_time) == et, {tag, " time"}, int'(rec_time), et);
            check(int'(rec_width) == ew, {tag, " width"}, int'(rec_width), ew);
            check(rec_ovf == eo, {tag, " ovf"}, int'(rec_ovf), int'(eo));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; word_valid = 0; start = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_in = 0; m_coarse = 0;
    endtask

    function automatic logic [15:0] pick_word(input int kind);
        int k = int'($urandom % 16);
        case (kind)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'(1 << k);
            3: return 16'((1 << k) - 1);
            4: return ~16'((1 << k) - 1);
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #4_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        do_reset();
        #2;
        check(rec_valid == 1'b0, "R1 reset strobe", int'(rec_valid), 0);

        // multi-word pulse starting at offset 0
        step(16'hFFFF, 1, 0, "R5");
        step(16'hF800, 1, 0, "R5");
        step(16'h0000, 1, 0, "R5");
        // single-bit pulse at offset 4
        step(16'h0800, 1, 0, "R6");
        // empty word then late edge
        step(16'h0000, 1, 0, "R2");
        step(16'h0001, 1, 0, "R2");
        step(16'hFFFF, 1, 0, "R5");
        step(16'hF000, 1, 0, "R5");
        step(16'h3FF0, 1, 0, "R2");
        // run filled the word, falling edge at bit 15 of next word
        step(16'h00FF, 1, 0, "R4");
        step(16'h0F00, 1, 0, "R4");
        // end and reopen in one word
        step(16'h0003, 1, 0, "R7");
        step(16'hF00F, 1, 0, "R7");
        step(16'h8000, 1, 0, "R7");
        // second inner pulse discarded
        step(16'hA000, 1, 0, "R8");
        step(16'h0000, 1, 0, "R8");
        step(16'h4C31, 1, 0, "R8");
        step(16'h0000, 1, 0, "R8");
        // invalid cycles and restart
        step(16'hFFFF, 0, 0, "R3");
        step(16'h0040, 1, 0, "R3");
        step(16'h0001, 1, 0, "R3");
        step(16'h0000, 0, 1, "R3");
        step(16'h0000, 1, 0, "R3");
        step(16'h0100, 1, 0, "R3");
        // reset mid-pulse
        step(16'h0001, 1, 0, "R1");
        do_reset();
        step(16'h0000, 1, 0, "R1");
        // width 4095 exactly, then 4096
        step(16'h7FFF, 1, 0, "R9");
        for (int i = 0; i < 255; i++) step(16'hFFFF, 1, 0, "R9");
        step(16'h0000, 1, 0, "R9");
        step(16'hFFFF, 1, 0, "R9");
        for (int i = 0; i < 255; i++) step(16'hFFFF, 1, 0, "R9");
        step(16'h0000, 1, 0, "R9");
        step(16'h0001, 1, 0, "R9");
        for (int i = 0; i < 300; i++) step(16'hFFFF, 1, 0, "R9");
        step(16'h7000, 1, 0, "R9");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            if (r < 2)       step(16'h0000, 0, 1, "R3 rand");
            else if (r < 10) step(16'($urandom), 0, 0, "R3 rand");
            else             step(pick_word(int'($urandom % 7)), 1, 0, "R4 rand");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule